// File: doc/BRIEF.md
# Microcoded Control Sequencer for a 16-bit Processor

This block is the control unit of a small 16-bit multi-cycle processor. A micro-program counter selects a word from a computed microcode store. Each word carries the datapath control bits and a next-address choice. Every instruction first runs two shared micro-states. The fetch state loads the instruction register and bumps the program counter. The decode state has the ALU form an optimistic branch target and then jumps through an opcode-indexed dispatch table into a short routine. Each routine finishes by sending the micro-program counter back to zero.

The instruction register and the equal flag from the ALU are the only data inputs. The block drives the datapath through its outputs:

- write enables for the register file, program counter, memory, instruction register and memory data register;
- the ALU operand and operation selects;
- the register write-data source and the destination format bit.

Every control output is a function of the micro-program counter alone, with two exceptions. The PC write also depends on the equal flag. The ALU function passes the instruction's function field through when the micro-word does not fix the operation.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the micro-program counter becomes 0. Out of reset the fetch controls are presented.
- R2: Micro-address 0 is fetch. It asserts `ir_wr` and `pc_inc` and no other write enable, and it always moves on to micro-address 1.
- R3: Micro-address 1 is decode. It selects PC as ALU input A and the sign-extended offset (`alu_b_sel`=1) as input B, with `alu_fn`=0 (add). It dispatches on IR[15:12]: 0→0x10, 1→0x20, 2→0x28, 3→0x40, 4→0x50, 5→0x60, 6→0x70, 7→0x78.
- R4: Opcodes 8 to 15 dispatch to 0x08. That single state asserts no enable and returns to fetch.
- R5: The register-register routine is two states, at 0x10 and 0x11. The first selects R0 and R1 (`alu_a_r0`=1, `alu_b_sel`=0) with `alu_fn` equal to IR[3:0]. The second asserts `reg_wr` with ALU data (`reg_src_mdr`=0) and returns.
- R6: The shift routines start at 0x20 (left, `alu_fn`=4) and 0x28 (right, `alu_fn`=5). Each uses R0 and fixes the operation from microcode, then writes the register file from the ALU with `reg_fmt`=1 and returns.
- R7: The load routine is three states. The first computes R0 plus the sign-extended offset with add. The second asserts `iod` and `mdr_wr`. The third asserts `reg_wr` with `reg_src_mdr`=1 and `reg_fmt`=1 and returns.
- R8: The store routine computes R0 plus the sign-extended offset with add at 0x50. At 0x51 it asserts `iod` and `mem_wr` and returns. `mem_wr` is never high without `iod`.
- R9: The add-immediate routine computes R0 plus the sign-extended offset with add. It then writes the register file from the ALU with `reg_fmt`=1 and returns.
- R10: The compare-branch routine is one state. It uses R0 and R1 with `alu_fn`=1 (subtract) and asserts `pc_src_br`. It asserts `pc_wr` only when `eq` is high.
- R11: The jump routine is one state. It asserts `pc_wr` whatever `eq` is, with `pc_src_br`=0.
- R12: When a word's operation is fixed, `alu_fn` is {0, op} with add=0, sub=1, and=2, or=3, sll=4, srl=5. Otherwise `alu_fn` is IR[3:0]. The last state of every routine is followed by micro-address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir | input | 16 | Instruction register contents |
| eq | input | 1 | ALU equal flag |
| reg_wr | output | 1 | Register file write enable |
| reg_src_mdr | output | 1 | Register write data from MDR (else ALU result) |
| reg_fmt | output | 1 | Destination register from IR[10] (else IR[9]) |
| pc_inc | output | 1 | Increment program counter |
| pc_wr | output | 1 | Program counter write, already gated by eq when conditional |
| pc_src_br | output | 1 | PC write data is branch target (else jump target) |
| iod | output | 1 | Memory address from ALU result (else PC) |
| mem_wr | output | 1 | Memory write enable |
| ir_wr | output | 1 | Instruction register write enable |
| mdr_wr | output | 1 | Memory data register write enable |
| alu_a_r0 | output | 1 | ALU input A is R0 (else PC) |
| alu_b_sel | output | 2 | ALU input B: 0 R1, 1 sign-extended offset, 2 truncated offset |
| alu_fn | output | 4 | ALU function code |
| upc | output | 8 | Current micro-program counter |

## Verification
On every cycle, assertions check several structural rules:

- fetch always leads to decode;
- decode never stays in decode or falls back to fetch;
- a returning word always lands on address 0;
- the instruction register is written only in fetch;
- memory and MDR writes come only with the ALU-sourced address;
- a reset edge clears the micro-program counter.

Only the scoreboard scenarios can show that each opcode reaches its own routine with the exact per-state control pattern and routine length. The same holds for the ALU function passing IR[3:0] through only when the word does not fix it, and for the equal flag gating the PC write only in the compare-branch state. A reset taken in the middle of a routine is also covered by the scenarios.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    NX_STEP     = 2'd0,
    NX_DISPATCH = 2'd1,
    NX_FETCH    = 2'd2
  } nx_e;

  typedef enum logic [1:0] {
    SRC_B_R1    = 2'd0,
    SRC_B_SEXT  = 2'd1,
    SRC_B_TRUNC = 2'd2
  } srcb_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_SLL = 3'd4,
    OP_SRL = 3'd5
  } aluop_e;

  typedef struct packed {
    nx_e    nx;
    logic   reg_wr;
    logic   reg_src_mdr;
    logic   reg_fmt;
    logic   pc_inc;
    logic   pc_wr;
    logic   pc_wr_if_eq;
    logic   pc_src_br;
    logic   iod;
    logic   mem_wr;
    logic   ir_wr;
    logic   mdr_wr;
    logic   alu_a_r0;
    srcb_e  alu_b;
    logic   op_fixed;
    aluop_e alu_op;
  } uword_t;

  localparam logic [7:0] UA_FETCH  = 8'h00;
  localparam logic [7:0] UA_DECODE = 8'h01;
  localparam logic [7:0] UA_IDLE   = 8'h08;
  localparam logic [7:0] UA_RR     = 8'h10;
  localparam logic [7:0] UA_SHL    = 8'h20;
  localparam logic [7:0] UA_SHR    = 8'h28;
  localparam logic [7:0] UA_LOAD   = 8'h40;
  localparam logic [7:0] UA_STORE  = 8'h50;
  localparam logic [7:0] UA_ADDI   = 8'h60;
  localparam logic [7:0] UA_BEQ    = 8'h70;
  localparam logic [7:0] UA_JUMP   = 8'h78;

  function automatic logic [7:0] dispatch_target(input logic [7:0] op);
    case (op)
      8'd0:    return UA_RR;
      8'd1:    return UA_SHL;
      8'd2:    return UA_SHR;
      8'd3:    return UA_LOAD;
      8'd4:    return UA_STORE;
      8'd5:    return UA_ADDI;
      8'd6:    return UA_BEQ;
      8'd7:    return UA_JUMP;
      default: return UA_IDLE;
    endcase
  endfunction

  function automatic uword_t ucode_word(input logic [7:0] addr);
    uword_t w;
    w = '0;
    w.nx = NX_FETCH;
    case (addr)
      UA_FETCH: begin
        w.nx = NX_STEP; w.ir_wr = 1'b1; w.pc_inc = 1'b1;
      end
      UA_DECODE: begin
        w.nx = NX_DISPATCH; w.alu_b = SRC_B_SEXT;
        w.op_fixed = 1'b1; w.alu_op = OP_ADD;
      end
      UA_RR: begin
        w.nx = NX_STEP; w.alu_a_r0 = 1'b1; w.alu_b = SRC_B_R1;
      end
      UA_RR + 8'd1: begin
        w.reg_wr = 1'b1;
      end
      UA_SHL, UA_SHR: begin
        w.nx = NX_STEP; w.alu_a_r0 = 1'b1; w.op_fixed = 1'b1;
        w.alu_op = (addr == UA_SHL) ? OP_SLL : OP_SRL;
      end
      UA_SHL + 8'd1, UA_SHR + 8'd1, UA_ADDI + 8'd1: begin
        w.reg_wr = 1'b1; w.reg_fmt = 1'b1;
      end
      UA_LOAD, UA_STORE, UA_ADDI: begin
        w.nx = NX_STEP; w.alu_a_r0 = 1'b1; w.alu_b = SRC_B_SEXT;
        w.op_fixed = 1'b1; w.alu_op = OP_ADD;
      end
      UA_LOAD + 8'd1: begin
        w.nx = NX_STEP; w.iod = 1'b1; w.mdr_wr = 1'b1;
      end
      UA_LOAD + 8'd2: begin
        w.reg_wr = 1'b1; w.reg_src_mdr = 1'b1; w.reg_fmt = 1'b1;
      end
      UA_STORE + 8'd1: begin
        w.iod = 1'b1; w.mem_wr = 1'b1;
      end
      UA_BEQ: begin
        w.alu_a_r0 = 1'b1; w.alu_b = SRC_B_R1; w.op_fixed = 1'b1;
        w.alu_op = OP_SUB; w.pc_wr_if_eq = 1'b1; w.pc_src_br = 1'b1;
      end
      UA_JUMP: begin
        w.pc_wr = 1'b1;
      end
      default: ;
    endcase
    return w;
  endfunction

  function automatic logic [3:0] alu_fn_sel(input logic fixed, input aluop_e op,
                                            input logic [3:0] func);
    return fixed ? {1'b0, op} : func;
  endfunction

endpackage

// File: rtl/mc_dispatch.sv
module mc_dispatch #(
  parameter int OP_W = 4,
  parameter int UA_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  output logic [UA_W-1:0] target
);
  localparam int N_OPS = 1 << OP_W;

  logic [UA_W-1:0] table_q [N_OPS];

  for (genvar i = 0; i < N_OPS; i++) begin : g_tab
    assign table_q[i] = UA_W'(mc_pkg::dispatch_target(8'(i)));
  end

  assign target = table_q[opcode];
endmodule

// File: rtl/mc_ucode_rom.sv
module mc_ucode_rom #(
  parameter int UA_W = 8
) (
  input  logic [UA_W-1:0] addr,
  output mc_pkg::uword_t  word
);
  assign word = mc_pkg::ucode_word(8'(addr));
endmodule

// File: rtl/mc_next_sel.sv
module mc_next_sel #(
  parameter int UA_W = 8
) (
  input  mc_pkg::nx_e     nx,
  input  logic [UA_W-1:0] upc,
  input  logic [UA_W-1:0] disp_addr,
  output logic [UA_W-1:0] upc_next
);
  always_comb begin
    case (nx)
      mc_pkg::NX_STEP:     upc_next = upc + UA_W'(1);
      mc_pkg::NX_DISPATCH: upc_next = disp_addr;
      default:             upc_next = '0;
    endcase
  end
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer #(
  parameter int IR_W = 16,
  parameter int OP_W = 4,
  parameter int UA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IR_W-1:0] ir,
  input  logic            eq,
  output logic            reg_wr,
  output logic            reg_src_mdr,
  output logic            reg_fmt,
  output logic            pc_inc,
  output logic            pc_wr,
  output logic            pc_src_br,
  output logic            iod,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            mdr_wr,
  output logic            alu_a_r0,
  output logic [1:0]      alu_b_sel,
  output logic [3:0]      alu_fn,
  output logic [UA_W-1:0] upc
);
  import mc_pkg::*;

  localparam int OP_LSB = IR_W - OP_W;

  logic [UA_W-1:0] upc_q, upc_next, disp_addr;
  uword_t          uw;
  logic            returning;

  mc_dispatch #(.OP_W(OP_W), .UA_W(UA_W)) u_disp (
    .opcode (ir[IR_W-1:OP_LSB]),
    .target (disp_addr)
  );

  mc_ucode_rom #(.UA_W(UA_W)) u_rom (
    .addr (upc_q),
    .word (uw)
  );

  mc_next_sel #(.UA_W(UA_W)) u_next (
    .nx        (uw.nx),
    .upc       (upc_q),
    .disp_addr (disp_addr),
    .upc_next  (upc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= '0;
    else     upc_q <= upc_next;
  end

  assign returning   = (uw.nx == NX_FETCH);
  assign upc         = upc_q;
  assign reg_wr      = uw.reg_wr;
  assign reg_src_mdr = uw.reg_src_mdr;
  assign reg_fmt     = uw.reg_fmt;
  assign pc_inc      = uw.pc_inc;
  assign pc_wr       = uw.pc_wr | (uw.pc_wr_if_eq & eq);
  assign pc_src_br   = uw.pc_src_br;
  assign iod         = uw.iod;
  assign mem_wr      = uw.mem_wr;
  assign ir_wr       = uw.ir_wr;
  assign mdr_wr      = uw.mdr_wr;
  assign alu_a_r0    = uw.alu_a_r0;
  assign alu_b_sel   = uw.alu_b;
  assign alu_fn      = alu_fn_sel(uw.op_fixed, uw.alu_op, ir[3:0]);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (upc_q == '0));

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    (upc_q == UA_W'(UA_FETCH)) |=> (upc_q == UA_W'(UA_DECODE)));

  assert_irwr_in_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    ir_wr |-> (upc_q == UA_W'(UA_FETCH)));

  assert_decode_leaves_R3: assert property (@(posedge clk) disable iff (rst)
    (upc_q == UA_W'(UA_DECODE)) |=> (upc_q != UA_W'(UA_DECODE) && upc_q != '0));

  assert_memwr_needs_iod_R8: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> iod);

  assert_mdrwr_needs_iod_R7: assert property (@(posedge clk) disable iff (rst)
    mdr_wr |-> iod);

  assert_return_to_fetch_R12: assert property (@(posedge clk) disable iff (rst)
    returning |=> (upc_q == '0));

endmodule

// File: tb/mc_sequencer_tb.sv
`timescale 1ns/100ps
module mc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ir  = '0;
  logic        eq  = 1'b0;
  logic        reg_wr, reg_src_mdr, reg_fmt, pc_inc, pc_wr, pc_src_br;
  logic        iod, mem_wr, ir_wr, mdr_wr, alu_a_r0;
  logic [1:0]  alu_b_sel;
  logic [3:0]  alu_fn;
  logic [7:0]  upc;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [24:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mc_sequencer dut_i (
    .clk(clk), .rst(rst), .ir(ir), .eq(eq),
    .reg_wr(reg_wr), .reg_src_mdr(reg_src_mdr), .reg_fmt(reg_fmt),
    .pc_inc(pc_inc), .pc_wr(pc_wr), .pc_src_br(pc_src_br), .iod(iod),
    .mem_wr(mem_wr), .ir_wr(ir_wr), .mdr_wr(mdr_wr), .alu_a_r0(alu_a_r0),
    .alu_b_sel(alu_b_sel), .alu_fn(alu_fn), .upc(upc)
  );

  function automatic int body_len(input logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd4, 4'd5: return 2;
      4'd3:                         return 3;
      default:                      return 1;
    endcase
  endfunction

  function automatic logic [7:0] body_base(input logic [3:0] op);
    case (op)
      4'd0: return 8'h10;  4'd1: return 8'h20;  4'd2: return 8'h28;
      4'd3: return 8'h40;  4'd4: return 8'h50;  4'd5: return 8'h60;
      4'd6: return 8'h70;  4'd7: return 8'h78;
      default: return 8'h08;
    endcase
  endfunction

  // Expected outputs for a given step of an instruction, from R2..R12.
  function automatic logic [24:0] expect_vec(input logic [3:0] op, input int step,
                                             input logic [3:0] func, input logic e);
    logic rw = 0, rsm = 0, rf = 0, pi = 0, pw = 0, psb = 0, io = 0, mw = 0;
    logic iw = 0, mdw = 0, ar0 = 0;
    logic [1:0] bs = 2'd0;
    logic [3:0] fn;
    logic [7:0] ua;
    fn = func;
    if (step == 0) begin
      ua = 8'h00; iw = 1; pi = 1;
    end else if (step == 1) begin
      ua = 8'h01; bs = 2'd1; fn = 4'd0;
    end else begin
      ua = body_base(op) + 8'(step - 2);
      case (op)
        4'd0: if (step == 2) ar0 = 1; else rw = 1;
        4'd1, 4'd2:
          if (step == 2) begin ar0 = 1; fn = (op == 4'd1) ? 4'd4 : 4'd5; end
          else begin rw = 1; rf = 1; end
        4'd3:
          if (step == 2) begin ar0 = 1; bs = 2'd1; fn = 4'd0; end
          else if (step == 3) begin io = 1; mdw = 1; end
          else begin rw = 1; rsm = 1; rf = 1; end
        4'd4:
          if (step == 2) begin ar0 = 1; bs = 2'd1; fn = 4'd0; end
          else begin io = 1; mw = 1; end
        4'd5:
          if (step == 2) begin ar0 = 1; bs = 2'd1; fn = 4'd0; end
          else begin rw = 1; rf = 1; end
        4'd6: begin ar0 = 1; fn = 4'd1; psb = 1; pw = e; end
        4'd7: pw = 1;
        default: ;
      endcase
    end
    return {rw, rsm, rf, pi, pw, psb, io, mw, iw, mdw, ar0, bs, fn, ua};
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0: return "R5";  4'd1: return "R6";  4'd2: return "R6";
      4'd3: return "R7";  4'd4: return "R8";  4'd5: return "R9";
      4'd6: return "R10"; 4'd7: return "R11";
      default: return "R4";
    endcase
  endfunction

  task automatic push(input logic [24:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // Driver: loads one instruction and queues every cycle's expected controls.
  task automatic run_instr(input logic [3:0] op, input logic [3:0] func, input logic e);
    int n;
    n = body_len(op);
    ir = {op, 8'h5A, func};
    eq = e;
    push(expect_vec(op, 0, func, e), "R2");
    push(expect_vec(op, 1, func, e), "R3");
    for (int s = 2; s < n + 2; s++)
      push(expect_vec(op, s, func, e), (s == n + 1) ? {op_tag(op), "/R12"} : op_tag(op));
    repeat (n + 2) @(posedge clk);
    #1;
  endtask

  // Monitor: compares one queued item per falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [24:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {reg_wr, reg_src_mdr, reg_fmt, pc_inc, pc_wr, pc_src_br, iod, mem_wr,
           ir_wr, mdr_wr, alu_a_r0, alu_b_sel, alu_fn, upc};
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    push(expect_vec(4'd0, 0, 4'd0, 1'b0), "R1");
    @(posedge clk); #1;
    rst = 1'b0;

    run_instr(4'd0, 4'h3, 1'b1);   // R5 register-register, eq ignored
    run_instr(4'd0, 4'hA, 1'b0);   // R5 different function field
    run_instr(4'd1, 4'h7, 1'b0);   // R6 shift left
    run_instr(4'd2, 4'h2, 1'b1);   // R6 shift right
    run_instr(4'd3, 4'h1, 1'b0);   // R7 load
    run_instr(4'd4, 4'hF, 1'b0);   // R8 store
    run_instr(4'd5, 4'h6, 1'b0);   // R9 add immediate
    run_instr(4'd6, 4'h9, 1'b1);   // R10 branch taken
    run_instr(4'd6, 4'h9, 1'b0);   // R10 branch not taken
    run_instr(4'd7, 4'h4, 1'b0);   // R11 jump with eq low
    run_instr(4'd7, 4'h4, 1'b1);   // R11 jump with eq high
    run_instr(4'd8, 4'h0, 1'b1);   // R4 unused opcode
    run_instr(4'd15, 4'hC, 1'b0);  // R4 highest opcode

    // R1: reset taken in the middle of the load routine
    ir = {4'd3, 8'h00, 4'h2};
    eq = 1'b0;
    push(expect_vec(4'd3, 0, 4'h2, 1'b0), "R2");
    push(expect_vec(4'd3, 1, 4'h2, 1'b0), "R3");
    push(expect_vec(4'd3, 2, 4'h2, 1'b0), "R7");
    repeat (2) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1;
    push(expect_vec(4'd0, 0, 4'h2, 1'b0), "R1");
    @(posedge clk); #1;
    rst = 1'b0;
    run_instr(4'd4, 4'h1, 1'b1);   // R8 after reset recovery

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule